// File: doc/BRIEF.md
# Data EEPROM Controller with Pattern Fill

This block sits on a microcontroller's special-function-register bus and drives a 512-byte non-volatile data store, modelled here as a synthesizable byte array. Software reaches it through three byte-wide registers: a control/status register, a low address register and a data register. A 9-bit array address is formed from control bit 0 (address bit 8) and the eight bits of the address register.

Every command starts with a write to the address register. The mode field and a "data written" marker decide what that write means. In byte mode it starts either a read or a single-byte program. In row mode it fills one 64-byte row with the data-register pattern. In block mode it fills the whole array. Programming operations hold the block busy for a long, parameterised program time. Reads finish after a few cycles. When a command ends, a sticky completion flag is set, and it can raise an interrupt request when two enables allow it. A high-voltage fault input latches into a status bit.

Top module: `nvdata_ctl`

## Requirements
- R1: Control register readback is {bit7 done flag, bit6 fault flag, bits5:4 mode, bits3:1 always 0, bit0 address bit 8}. Writing the control register sets the mode and address bit 8. Register select codes are 0 = control, 1 = address, 2 = data, and 3 reads 0.
- R2: The array address is {control bit 0, address register}, so bytes 0x0C3 and 0x1C3 are separate.
- R3: Mode 00 with no data-register write since the last command is a read. Busy is high for exactly READ_CYC cycles, then the data register holds the addressed byte.
- R4: Mode 00 after a data-register write is a byte program of that data. Busy is high for exactly PROG_CYC cycles, and the marker is cleared afterwards.
- R5: Mode 10 writes the data pattern to all 64 bytes of the row chosen by address bits 8:6, ignores address bits 5:0, leaves bytes outside the row unchanged, and stays busy for PROG_CYC cycles.
- R6: Mode 11 with address bit 8 = 1 writes the pattern to all 512 bytes and stays busy for PROG_CYC cycles.
- R7: An address write in mode 01, or in mode 11 with address bit 8 = 0, starts nothing. Busy stays low, the flag stays clear and the array is unchanged.
- R8: The done flag is set in the cycle a command ends. It is cleared only by a control write with bit 7 = 0. Writing 1 leaves it as it is.
- R9: irq is a register equal to the previous cycle's done flag AND ie_periph AND ie_global.
- R10: While busy, writes to the address and data registers and to the mode and address-bit-8 control fields are ignored.
- R11: A cycle with hv_fault high sets bit 6. It stays set until a control write with bit 6 = 0.
- R12: After reset, all registers read 0, and busy and irq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register selected for the write |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Register selected for readback |
| rd_data | output | 8 | Registered readback, one cycle after rd_sel |
| ie_periph | input | 1 | Peripheral interrupt enable |
| ie_global | input | 1 | Global interrupt enable |
| hv_fault | input | 1 | Programming-voltage fault indication |
| busy | output | 1 | Command in progress |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions check on every cycle that irq follows the gated flag, that the flag rises only as busy falls and holds until it is cleared, that a reserved-mode start never raises busy, and that address and mode writes during busy leave those registers untouched. Only the bench scenarios can show what reaches the array: the exact busy lengths, the row boundaries of a fill, the block-fill guard on address bit 8, the split between read and program caused by the data-written marker, and agreement with a byte-level model under random traffic.

// File: rtl/nvd_pkg.sv
package nvd_pkg;
  typedef enum logic [1:0] {
    M_BYTE  = 2'b00,
    M_RSVD  = 2'b01,
    M_ROW   = 2'b10,
    M_BLOCK = 2'b11
  } nvd_mode_e;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;
endpackage

// File: rtl/nvd_array.sv
module nvd_array #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // simple dual-port, registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/nvd_seq.sv
module nvd_seq #(
  parameter int ADDR_W   = 9,
  parameter int PROG_CYC = 800000,
  parameter int READ_CYC = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              read_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W:0]   len_i,
  output logic              busy_o,
  output logic              last_o,
  output logic              read_last_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o
);
  localparam int CNT_W = $clog2(PROG_CYC + 1);

  logic              busy_q, read_q;
  logic [CNT_W-1:0]  cnt_q, lim;
  logic [ADDR_W:0]   fidx_q, len_q;
  logic [ADDR_W-1:0] base_q;

  assign lim         = read_q ? CNT_W'(READ_CYC) : CNT_W'(PROG_CYC);
  assign last_o      = busy_q && (cnt_q == lim - 1'b1);
  assign read_last_o = last_o && read_q;
  assign busy_o      = busy_q;
  assign we_o        = busy_q && !read_q && (fidx_q < len_q);
  assign waddr_o     = base_q | fidx_q[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      read_q <= 1'b0;
      cnt_q  <= '0;
      fidx_q <= '0;
      len_q  <= '0;
      base_q <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      read_q <= read_i;
      cnt_q  <= '0;
      fidx_q <= '0;
      len_q  <= len_i;
      base_q <= base_i;
    end else if (busy_q) begin
      if (last_o) busy_q <= 1'b0;
      else        cnt_q  <= cnt_q + 1'b1;
      if (we_o)   fidx_q <= fidx_q + 1'b1;
    end
  end
endmodule

// File: rtl/nvdata_ctl.sv
module nvdata_ctl
  import nvd_pkg::*;
#(
  parameter int ADDR_W   = 9,
  parameter int DATA_W   = 8,
  parameter int ROW_W    = 6,
  parameter int PROG_CYC = 800000,
  parameter int READ_CYC = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ie_periph,
  input  logic              ie_global,
  input  logic              hv_fault,
  output logic              busy,
  output logic              irq
);
  localparam int LO_W    = ADDR_W - 1;
  localparam int LEN_W   = ADDR_W + 1;
  localparam int ROW_LEN = 1 << ROW_W;
  localparam int ARR_LEN = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] ROW_MASK = {{(ADDR_W-ROW_W){1'b1}}, {ROW_W{1'b0}}};

  logic              flag_q, hverr_q, hi_q, dw_q, irq_q;
  nvd_mode_e         mode_q;
  logic [LO_W-1:0]   addr_q;
  logic [DATA_W-1:0] data_q, rd_q, mem_q;

  logic              addr_wr, data_wr, ctrl_wr;
  logic              start, is_read;
  logic [ADDR_W-1:0] full_addr, base;
  logic [LEN_W-1:0]  len;
  logic              last, read_last, mem_we;
  logic [ADDR_W-1:0] mem_waddr;

  assign ctrl_wr   = wr_en && (wr_sel == SEL_CTRL);
  assign addr_wr   = wr_en && (wr_sel == SEL_ADDR) && !busy;
  assign data_wr   = wr_en && (wr_sel == SEL_DATA) && !busy;
  assign full_addr = {hi_q, wr_data[LO_W-1:0]};

  always_comb begin
    start   = 1'b0;
    is_read = 1'b0;
    base    = full_addr;
    len     = LEN_W'(1);
    unique case (mode_q)
      M_BYTE: begin
        start   = addr_wr;
        is_read = !dw_q;
      end
      M_ROW: begin
        start = addr_wr;
        base  = full_addr & ROW_MASK;
        len   = LEN_W'(ROW_LEN);
      end
      M_BLOCK: begin
        start = addr_wr && hi_q;
        base  = '0;
        len   = LEN_W'(ARR_LEN);
      end
      default: start = 1'b0;
    endcase
  end

  nvd_seq #(
    .ADDR_W(ADDR_W), .PROG_CYC(PROG_CYC), .READ_CYC(READ_CYC)
  ) u_seq (
    .clk(clk), .rst(rst), .start_i(start), .read_i(is_read),
    .base_i(base), .len_i(len), .busy_o(busy), .last_o(last),
    .read_last_o(read_last), .we_o(mem_we), .waddr_o(mem_waddr)
  );

  nvd_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(data_q),
    .raddr({hi_q, addr_q}), .rdata(mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= 1'b0;
      hverr_q <= 1'b0;
      mode_q  <= M_BYTE;
      hi_q    <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      dw_q    <= 1'b0;
      irq_q   <= 1'b0;
      rd_q    <= '0;
    end else begin
      // status flags: hardware set wins over a software clear
      flag_q  <= last     | (flag_q  & ~(ctrl_wr & ~wr_data[7]));
      hverr_q <= hv_fault | (hverr_q & ~(ctrl_wr & ~wr_data[6]));
      if (ctrl_wr && !busy) begin
        mode_q <= nvd_mode_e'(wr_data[5:4]);
        hi_q   <= wr_data[0];
      end
      if (addr_wr) begin
        addr_q <= wr_data[LO_W-1:0];
        dw_q   <= 1'b0;
      end
      if (data_wr) begin
        data_q <= wr_data;
        dw_q   <= 1'b1;
      end else if (read_last) begin
        data_q <= mem_q;
      end
      irq_q <= flag_q & ie_periph & ie_global;
      unique case (rd_sel)
        SEL_CTRL: rd_q <= {flag_q, hverr_q, mode_q, 3'b000, hi_q};
        SEL_ADDR: rd_q <= addr_q;
        SEL_DATA: rd_q <= data_q;
        default:  rd_q <= '0;
      endcase
    end
  end

  assign rd_data = rd_q;
  assign irq     = irq_q;
endmodule

// File: rtl/nvd_chk.sv
module nvd_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [1:0] wr_sel,
  input logic [7:0] wr_data,
  input logic       ie_periph,
  input logic       ie_global,
  input logic       hv_fault,
  input logic       busy,
  input logic       irq,
  input logic       flag,
  input logic       hverr,
  input logic [1:0] mode,
  input logic [7:0] addr_q
);
  p_irq_gate_r9: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(flag && ie_periph && ie_global));

  p_irq_raise_r9: assert property (@(posedge clk) disable iff (rst)
    (flag && ie_periph && ie_global) |=> irq);

  p_flag_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (flag && !(wr_en && wr_sel == 2'd0 && !wr_data[7])) |=> flag);

  p_flag_at_end_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $fell(busy));

  p_rsvd_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (!busy && wr_en && wr_sel == 2'd1 && mode == 2'b01) |=> !busy);

  p_addr_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_en && wr_sel == 2'd1) |=> $stable(addr_q));

  p_mode_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_en && wr_sel == 2'd0) |=> $stable(mode));

  p_fault_latch_r11: assert property (@(posedge clk) disable iff (rst)
    hv_fault |=> hverr);
endmodule

bind nvdata_ctl nvd_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .ie_periph(ie_periph), .ie_global(ie_global), .hv_fault(hv_fault),
  .busy(busy), .irq(irq), .flag(flag_q), .hverr(hverr_q),
  .mode(mode_q), .addr_q(addr_q)
);

// File: tb/sim_nvdata_ctl.sv
module sim_nvdata_ctl;
  localparam int PROG = 700;
  localparam int RDC  = 3;
  localparam logic [1:0] S_CTRL = 2'd0, S_ADDR = 2'd1, S_DATA = 2'd2;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0, ie_periph = 1'b0, ie_global = 1'b0, hv_fault = 1'b0;
  logic [1:0] wr_sel = '0, rd_sel = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic busy, irq;

  always #2.5 clk = ~clk;

  nvdata_ctl #(.PROG_CYC(PROG), .READ_CYC(RDC)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .ie_periph(ie_periph),
    .ie_global(ie_global), .hv_fault(hv_fault), .busy(busy), .irq(irq)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] model [512];

  function automatic logic [7:0] ctrl_val(logic f, logic h, logic [1:0] m, logic a8);
    return {f, h, m, 3'b000, a8};
  endfunction

  function automatic logic [8:0] row_base(logic [8:0] a);
    return {a[8:6], 6'd0};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] s, logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] s, output logic [7:0] v);
    @(negedge clk); rd_sel = s;
    @(negedge clk); v = rd_data;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 5000) begin n++; @(negedge clk); end
  endtask

  task automatic set_ctrl(logic [1:0] m, logic a8);
    wr(S_CTRL, ctrl_val(1'b0, 1'b1, m, a8));
  endtask

  task automatic read_byte(logic [8:0] a, output logic [7:0] v, output int n);
    set_ctrl(2'b00, a[8]);
    wr(S_ADDR, a[7:0]);
    wait_idle(n);
    rd(S_DATA, v);
  endtask

  task automatic write_byte(logic [8:0] a, logic [7:0] d, output int n);
    set_ctrl(2'b00, a[8]);
    wr(S_DATA, d);
    wr(S_ADDR, a[7:0]);
    wait_idle(n);
    model[a] = d;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int n;
    logic [8:0] a;
    logic [7:0] d;
    void'($urandom(32'd20250));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R12 reset state
    rd(S_CTRL, v); chk("R12 ctrl", v, 8'h00);
    rd(S_ADDR, v); chk("R12 addr", v, 8'h00);
    rd(S_DATA, v); chk("R12 data", v, 8'h00);
    chk("R12 busy", busy, 1'b0);
    chk("R12 irq", irq, 1'b0);

    // R1 layout: reserved bits read 0, flag cannot be set by writing 1
    wr(S_CTRL, 8'hAF);
    rd(S_CTRL, v); chk("R1 ctrl layout", v, ctrl_val(1'b0, 1'b0, 2'b10, 1'b1));
    rd(2'd3, v); chk("R1 unused select", v, 8'h00);

    // R6 block fill
    set_ctrl(2'b11, 1'b1);
    wr(S_DATA, 8'h5A);
    wr(S_ADDR, 8'h00);
    wait_idle(n); chk("R6 block busy", n, PROG);
    for (int i = 0; i < 512; i++) model[i] = 8'h5A;
    rd(S_CTRL, v); chk("R8 flag after block", v, ctrl_val(1'b1, 1'b0, 2'b11, 1'b1));
    foreach (model[i]) if (i % 37 == 0 || i == 511) begin
      read_byte(9'(i), v, n); chk("R6 block content", v, model[i]);
    end

    // R7 reserved mode and guarded block fill
    set_ctrl(2'b01, 1'b1);
    wr(S_DATA, 8'h11);
    wr(S_ADDR, 8'h10);
    chk("R7 reserved busy", busy, 1'b0);
    rd(S_CTRL, v); chk("R7 reserved flag", v, ctrl_val(1'b0, 1'b0, 2'b01, 1'b1));
    set_ctrl(2'b11, 1'b0);
    wr(S_DATA, 8'h22);
    wr(S_ADDR, 8'h00);
    chk("R7 guard busy", busy, 1'b0);
    rd(S_CTRL, v); chk("R7 guard flag", v, ctrl_val(1'b0, 1'b0, 2'b11, 1'b0));
    read_byte(9'h110, v, n); chk("R7 array kept", v, 8'h5A);
    read_byte(9'h000, v, n); chk("R7 array kept low", v, 8'h5A);

    // R4 / R2 byte program
    write_byte(9'h1C3, 8'hA7, n); chk("R4 program busy", n, PROG);
    read_byte(9'h1C3, v, n); chk("R4 readback", v, 8'hA7);
    chk("R3 read busy", n, RDC);
    read_byte(9'h0C3, v, n); chk("R2 bit8 separates", v, 8'h5A);

    // R5 row fill, low bits ignored
    set_ctrl(2'b10, 1'b1);
    wr(S_DATA, 8'h3C);
    wr(S_ADDR, 8'h95);
    wait_idle(n); chk("R5 row busy", n, PROG);
    for (int i = 0; i < 64; i++) model[row_base(9'h195) + 9'(i)] = 8'h3C;
    read_byte(9'h180, v, n); chk("R5 row first", v, model[9'h180]);
    read_byte(9'h1BF, v, n); chk("R5 row last", v, model[9'h1BF]);
    read_byte(9'h17F, v, n); chk("R5 below row", v, model[9'h17F]);
    read_byte(9'h1C0, v, n); chk("R5 above row", v, model[9'h1C0]);
    read_byte(9'h1C3, v, n); chk("R5 other row kept", v, 8'hA7);

    // R9 interrupt gating (flag set by the last read)
    @(negedge clk); ie_periph = 1'b1; ie_global = 1'b1;
    @(negedge clk); chk("R9 irq both", irq, 1'b1);
    ie_global = 1'b0;
    @(negedge clk); chk("R9 irq global off", irq, 1'b0);
    ie_global = 1'b1;
    @(negedge clk); chk("R9 irq back", irq, 1'b1);
    // R8 writing 1 keeps, writing 0 clears
    wr(S_CTRL, ctrl_val(1'b1, 1'b0, 2'b00, 1'b0));
    rd(S_CTRL, v); chk("R8 write1 keeps", v[7], 1'b1);
    wr(S_CTRL, ctrl_val(1'b0, 1'b0, 2'b00, 1'b0));
    @(negedge clk); chk("R9 irq after clear", irq, 1'b0);
    rd(S_CTRL, v); chk("R8 write0 clears", v[7], 1'b0);
    ie_periph = 1'b0; ie_global = 1'b0;

    // R10 writes while busy
    wr(S_DATA, 8'h66);
    wr(S_ADDR, 8'h40);
    wr(S_DATA, 8'hEE);
    wr(S_ADDR, 8'h41);
    wr(S_CTRL, 8'h71);
    wait_idle(n);
    model[9'h040] = 8'h66;
    rd(S_CTRL, v); chk("R10 ctrl kept", v, ctrl_val(1'b1, 1'b0, 2'b00, 1'b0));
    rd(S_ADDR, v); chk("R10 addr kept", v, 8'h40);
    rd(S_DATA, v); chk("R10 data kept", v, 8'h66);
    read_byte(9'h041, v, n); chk("R10 no second op", v, model[9'h041]);
    read_byte(9'h040, v, n); chk("R10 first op done", v, 8'h66);

    // R11 fault latch
    @(negedge clk); hv_fault = 1'b1;
    @(negedge clk); hv_fault = 1'b0;
    rd(S_CTRL, v); chk("R11 fault set", v[6], 1'b1);
    wr(S_CTRL, ctrl_val(1'b1, 1'b1, 2'b00, 1'b0));
    rd(S_CTRL, v); chk("R11 fault kept", v[6], 1'b1);
    wr(S_CTRL, ctrl_val(1'b1, 1'b0, 2'b00, 1'b0));
    rd(S_CTRL, v); chk("R11 fault cleared", v[6], 1'b0);

    // R3 / R4 random traffic against the model
    for (int k = 0; k < 40; k++) begin
      a = 9'($urandom % 512);
      d = 8'($urandom);
      if ($urandom % 2 == 0) begin
        write_byte(a, d, n); chk("R4 random program busy", n, PROG);
      end else begin
        read_byte(a, v, n);
        chk("R3 random read", v, model[a]);
        chk("R3 random read busy", n, RDC);
      end
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule